// File: doc/BRIEF.md
# Serial Stereo Audio Input Receiver

This block receives a stereo PCM stream made of a bit clock, a word (channel) clock and one serial data line. It turns the stream into parallel left and right sample words and raises a one-cycle strobe each time a complete left/right pair is ready. All inputs are sampled in the block's own system clock, so the bit clock has to be slower than half the system clock rate. Edges of the bit clock are found by comparing each input with its value one system clock earlier.

Two options can be chosen while the block runs. The first is the framing: normal right-justified, with the word's last bit at the end of its half-frame, or I2S, with the MSB one bit clock after the word-clock edge. The second is which word-clock level carries the left channel. A separate three-wire serial control port shifts in a 16-bit mode word. The top three bits of that word pick the register to write. A framing or polarity change is held as pending and only becomes active at the word-clock edge that starts a left half-frame. Playback flags (mute, de-emphasis, double speed, zero detect) are kept in a second register and appear on output pins. Reset loads fixed defaults.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset the block is in right-justified framing with the left channel on word clock high (cfg_i2s=0, cfg_pol=0), and mute=0, deemph=0, dbl_speed=0, zero_det=1.
- R2: The mode word is shifted in MSB first on each rising edge of mc_clk and acted on at the rising edge of mc_latch. When bits [15:13] are 1,0,1, bit 7 is stored as the pending framing (1 = I2S) and bit 6 as the pending polarity.
- R3: When bits [15:13] of the mode word are 1,0,0, bit 0 drives mute, bit 1 deemph, bit 2 dbl_speed and bit 3 zero_det from the latch edge on. Any other address changes nothing. The flags change only at a latch edge.
- R4: In right-justified framing, data is taken MSB first on bit-clock rising edges. A word is the last 16 bits received before a word-clock change, and any earlier padding bits in the half-frame are dropped.
- R5: In I2S framing, the bit sampled on the first bit-clock rising edge after a word-clock change is ignored. The next 16 bits, MSB first, form the word, and the rest of the half-frame is ignored.
- R6: Channel mapping: in right-justified framing, left is word clock high when the polarity is 0. In I2S framing, left is word clock low when the polarity is 0. A polarity of 1 swaps the two levels in both framings.
- R7: pair_valid is high for exactly one system clock when a right word completes a pair after a left word. left_out and right_out then hold that pair, and left_out changes only after a bit-clock rising edge.
- R8: A pending framing or polarity setting is copied to cfg_i2s/cfg_pol only at a word-clock change that starts a left half-frame under the current setting, or at the first word-clock change after reset. The block never changes format in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck | input | 1 | Bit clock, synchronous to clk |
| lrck | input | 1 | Word/channel clock |
| sdata | input | 1 | Serial audio data |
| mc_clk | input | 1 | Mode word shift clock |
| mc_data | input | 1 | Mode word data |
| mc_latch | input | 1 | Mode word latch strobe |
| left_out | output | 16 | Last left sample |
| right_out | output | 16 | Last right sample |
| pair_valid | output | 1 | One-cycle strobe: new pair ready |
| cfg_i2s | output | 1 | Active framing, 1 = I2S |
| cfg_pol | output | 1 | Active word-clock polarity |
| mute | output | 1 | Mute flag |
| deemph | output | 1 | De-emphasis flag |
| dbl_speed | output | 1 | Double-speed flag |
| zero_det | output | 1 | Zero-detect enable flag |

## Verification
The assertions assume that bck, lrck, sdata and the control pins are already synchronous to clk, and that each stays at one level for at least two system clocks. The assertions also assume that lrck and sdata only change while bck is low. The bench meets this by driving every pin on the falling edge of clk and holding each bit-clock phase for two clocks. After each mode write it sends two settling frames before any checked frames. Because of this, the pending setting has taken effect and the left/right order is aligned again before values are compared.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int DATA_W = 16,
  parameter int MODE_W = 16,
  localparam int CNT_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bck,
  input  logic              lrck,
  input  logic              sdata,
  input  logic              mc_clk,
  input  logic              mc_data,
  input  logic              mc_latch,
  output logic [DATA_W-1:0] left_out,
  output logic [DATA_W-1:0] right_out,
  output logic              pair_valid,
  output logic              cfg_i2s,
  output logic              cfg_pol,
  output logic              mute,
  output logic              deemph,
  output logic              dbl_speed,
  output logic              zero_det
);
  localparam logic [2:0] ADDR_FMT  = 3'b101;
  localparam logic [2:0] ADDR_FLAG = 3'b100;
  localparam int FMT_BIT = 7;
  localparam int POL_BIT = 6;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic bck_q, mcc_q, mcl_q, lr_q;
  logic started, got_left, pend_i2s, pend_pol;
  logic [DATA_W-1:0] sr;
  logic [MODE_W-1:0] mword;
  logic [CNT_W-1:0]  cnt;

  wire bck_rise  = bck & ~bck_q;
  wire mcc_rise  = mc_clk & ~mcc_q;
  wire mcl_rise  = mc_latch & ~mcl_q;
  wire trans     = bck_rise && (lrck != lr_q);
  wire half_left = cfg_i2s ? (lr_q == cfg_pol) : (lr_q != cfg_pol);
  wire new_left  = cfg_i2s ? (lrck == cfg_pol) : (lrck != cfg_pol);
  wire [DATA_W-1:0] shifted = {sr[DATA_W-2:0], sdata};

  wire rj_cap  = trans && started && !cfg_i2s;
  wire i2s_cap = bck_rise && !trans && started && cfg_i2s && (cnt == LAST_BIT);
  wire cap     = rj_cap | i2s_cap;
  wire [DATA_W-1:0] cap_word = cfg_i2s ? shifted : sr;

  wire [2:0] addr = mword[MODE_W-1 -: 3];
  wire unused_mode = ^{mword[MODE_W-4:8], mword[5:4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q <= 1'b0;
      mcc_q <= 1'b0;
      mcl_q <= 1'b0;
    end else begin
      bck_q <= bck;
      mcc_q <= mc_clk;
      mcl_q <= mc_latch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      lr_q     <= 1'b0;
      cnt      <= '0;
      started  <= 1'b0;
      cfg_i2s  <= 1'b0;
      cfg_pol  <= 1'b0;
    end else if (bck_rise) begin
      sr   <= shifted;
      lr_q <= lrck;
      if (trans) begin
        started <= 1'b1;
        cnt     <= '0;
        if (new_left || !started) begin
          cfg_i2s <= pend_i2s;
          cfg_pol <= pend_pol;
        end
      end else if (cnt != '1) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_out   <= '0;
      right_out  <= '0;
      got_left   <= 1'b0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= cap && !half_left && got_left;
      if (cap) begin
        if (half_left) begin
          left_out <= cap_word;
          got_left <= 1'b1;
        end else begin
          right_out <= cap_word;
          got_left  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mword     <= '0;
      pend_i2s  <= 1'b0;
      pend_pol  <= 1'b0;
      mute      <= 1'b0;
      deemph    <= 1'b0;
      dbl_speed <= 1'b0;
      zero_det  <= 1'b1;
    end else begin
      if (mcc_rise) mword <= {mword[MODE_W-2:0], mc_data};
      if (mcl_rise) begin
        case (addr)
          ADDR_FMT: begin
            pend_i2s <= mword[FMT_BIT];
            pend_pol <= mword[POL_BIT];
          end
          ADDR_FLAG: begin
            mute      <= mword[0];
            deemph    <= mword[1];
            dbl_speed <= mword[2];
            zero_det  <= mword[3];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bck,
  input logic              lrck,
  input logic              mc_latch,
  input logic [DATA_W-1:0] left_out,
  input logic              pair_valid,
  input logic              cfg_i2s,
  input logic              cfg_pol,
  input logic              mute,
  input logic              deemph,
  input logic              dbl_speed,
  input logic              zero_det
);
  logic bck_d, lr_d, mcl_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_d <= 1'b0;
      lr_d  <= 1'b0;
      mcl_d <= 1'b0;
    end else begin
      bck_d <= bck;
      mcl_d <= mc_latch;
      if (bck && !bck_d) lr_d <= lrck;
    end
  end

  a_r1_reset_defaults: assert property (@(posedge clk)
    !rst_n |=> (!cfg_i2s && !cfg_pol && !mute && !deemph && !dbl_speed && zero_det));

  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  a_r7_left_on_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (left_out != $past(left_out)) |-> $past(bck && !bck_d));

  a_r8_cfg_at_word_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_i2s != $past(cfg_i2s)) || (cfg_pol != $past(cfg_pol)))
      |-> $past(bck && !bck_d && (lrck != lr_d)));

  a_r3_flags_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !(mc_latch && !mcl_d) |=> $stable({mute, deemph, dbl_speed, zero_det}));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bck(bck), .lrck(lrck), .mc_latch(mc_latch),
  .left_out(left_out), .pair_valid(pair_valid), .cfg_i2s(cfg_i2s),
  .cfg_pol(cfg_pol), .mute(mute), .deemph(deemph), .dbl_speed(dbl_speed),
  .zero_det(zero_det)
);

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bck = 1'b0, lrck = 1'b0, sdata = 1'b0;
  logic mc_clk = 1'b0, mc_data = 1'b0, mc_latch = 1'b0;
  logic [15:0] left_out, right_out;
  logic pair_valid, cfg_i2s, cfg_pol, mute, deemph, dbl_speed, zero_det;

  int total = 0, bad = 0;
  int rec_n = 0, wide_err = 0;
  logic [15:0] rec_l [64];
  logic [15:0] rec_r [64];
  logic prev_v = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_audio_rx u_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .bck(bck), .lrck(lrck), .sdata(sdata),
    .mc_clk(mc_clk), .mc_data(mc_data), .mc_latch(mc_latch),
    .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid),
    .cfg_i2s(cfg_i2s), .cfg_pol(cfg_pol), .mute(mute), .deemph(deemph),
    .dbl_speed(dbl_speed), .zero_det(zero_det)
  );

  always @(negedge clk) begin
    if (pair_valid && prev_v) wide_err++;
    if (pair_valid) begin
      rec_l[rec_n % 64] = left_out;
      rec_r[rec_n % 64] = right_out;
      rec_n++;
    end
    prev_v = pair_valid;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_mode(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      mc_clk = 1'b0; mc_data = w[i]; idle(2);
      mc_clk = 1'b1; idle(2);
    end
    mc_clk = 1'b0;
    mc_latch = 1'b1; idle(2);
    mc_latch = 1'b0; idle(2);
  endtask

  task automatic send_half(input logic lvl, input logic [15:0] w, input bit i2s);
    for (int b = 0; b < 32; b++) begin
      logic bitv;
      bitv = ~b[0] ^ w[b % 16];
      if (!i2s && b >= 16) bitv = w[31-b];
      if (i2s && b >= 1 && b <= 16) bitv = w[16-b];
      bck = 1'b0; lrck = lvl; sdata = bitv; idle(2);
      bck = 1'b1; idle(2);
    end
  endtask

  task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input bit i2s, input bit pol);
    logic lv;
    lv = i2s ? pol : ~pol;
    send_half(lv, l, i2s);
    send_half(~lv, r, i2s);
  endtask

  task automatic run_case(input string req, input bit i2s, input bit pol, input logic [15:0] seed);
    logic [15:0] tl [3];
    logic [15:0] tr [3];
    int base;
    for (int k = 0; k < 3; k++) begin
      tl[k] = seed ^ 16'(k * 16'h1357);
      tr[k] = ~seed ^ 16'(k * 16'h2468);
    end
    send_frame(16'h1111, 16'h2222, i2s, pol);
    send_frame(16'h3333, 16'h4444, i2s, pol);
    for (int k = 0; k < 3; k++) send_frame(tl[k], tr[k], i2s, pol);
    send_frame(16'h5A5A, 16'hA5A5, i2s, pol);
    idle(20);
    base = rec_n - (i2s ? 4 : 3);
    for (int k = 0; k < 3; k++) begin
      check(rec_l[(base + k) % 64] == tl[k], {req, " left"}, 32'(rec_l[(base + k) % 64]), 32'(tl[k]));
      check(rec_r[(base + k) % 64] == tr[k], {req, " right"}, 32'(rec_r[(base + k) % 64]), 32'(tr[k]));
    end
    check(cfg_i2s == i2s && cfg_pol == pol, {req, " active cfg"}, {cfg_i2s, cfg_pol}, {i2s, pol});
  endtask

  task automatic t_reset;
    check(cfg_i2s == 0 && cfg_pol == 0, "R1 cfg", {cfg_i2s, cfg_pol}, 0);
    check({mute, deemph, dbl_speed, zero_det} == 4'b0001, "R1 flags",
          {mute, deemph, dbl_speed, zero_det}, 4'b0001);
    check(pair_valid == 0, "R1 valid", pair_valid, 0);
  endtask

  task automatic t_mode(input logic [15:0] w, input bit i2s, input bit pol, input string req);
    logic oi, op;
    oi = cfg_i2s; op = cfg_pol;
    write_mode(w);
    check(cfg_i2s == oi && cfg_pol == op, "R8 held until word edge", {cfg_i2s, cfg_pol}, {oi, op});
    run_case(req, i2s, pol, w ^ 16'h6C3B);
  endtask

  task automatic t_flags;
    write_mode(16'h8007);
    check({mute, deemph, dbl_speed, zero_det} == 4'b1110, "R3 flag write",
          {mute, deemph, dbl_speed, zero_det}, 4'b1110);
    write_mode(16'h60FF);
    check({mute, deemph, dbl_speed, zero_det} == 4'b1110, "R3 other address ignored",
          {mute, deemph, dbl_speed, zero_det}, 4'b1110);
    run_case("R3 other address keeps cfg", 1'b0, 1'b1, 16'h0F0F);
    write_mode(16'h8008);
    check({mute, deemph, dbl_speed, zero_det} == 4'b0001, "R3 flag clear",
          {mute, deemph, dbl_speed, zero_det}, 4'b0001);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    run_case("R4 R6 right-justified default", 1'b0, 1'b0, 16'hBEEF);
    t_mode(16'hA080, 1'b1, 1'b0, "R2 R5 R6 I2S pol0");
    t_mode(16'hA0C0, 1'b1, 1'b1, "R5 R6 I2S pol1");
    t_mode(16'hA040, 1'b0, 1'b1, "R4 R6 right-justified pol1");
    t_flags();
    t_mode(16'hA000, 1'b0, 1'b0, "R2 R4 back to default");
    check(wide_err == 0, "R7 single-cycle strobe", wide_err, 0);
    check(rec_n > 0, "R7 strobe seen", rec_n, 1);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule